// File: doc/BRIEF.md
# I2C Configuration Target with Timed Commit

This block is a bus target on a two-wire I2C bus that holds five byte-wide configuration registers, indexed 0 to 4. A bus controller selects the block by its 7-bit device address. In a write frame the controller sends a register index and then any number of data bytes. In a read frame the block returns bytes starting at the current index. Each byte moves the index forward, and the index wraps from 4 to 0. Both bus lines pass through a short synchroniser, and START and STOP are detected from the filtered levels. The block pulls SDA low through an output-enable signal, so the line is open-drain.

Bytes written on the bus go into a working copy. When a STOP ends a frame that wrote at least one byte, a commit of fixed length starts. During the commit a busy flag is raised, and only when the commit ends is the working copy copied into the persistent copy. Reads and the decoded outputs always come from the persistent copy. A similar busy window follows reset, to model power-up. While busy is high, the block ignores a START, so a controller that addresses it sees no acknowledge. Index 0 drives the reference code, index 1 drives the slope code, and the two low bits of index 2 select an output gain. Indexes 3 and 4 and the upper six bits of index 2 are plain storage.

Top module: `cfg_i2c_target`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high, both judged on the synchronised lines. The block never pulls SDA low outside a frame that began with a START it accepted.
- R2: The first byte after a START is acknowledged only when its upper seven bits equal DEV_ADDR. Bit 0 of that byte selects the direction: 1 is read, 0 is write. On a mismatch the block does not acknowledge and ignores the bus until the next START.
- R3: In a write frame the second byte is the register index. It is acknowledged only if it is below 5, and otherwise the block does not acknowledge and ignores the rest of the frame. Each later data byte is acknowledged and stored at the index, and the index then advances, wrapping from 4 to 0.
- R4: A read frame returns the register at the current index, most significant bit first, and advances the index after each byte. A controller acknowledge requests the next byte, and a not-acknowledge ends the transfer.
- R5: A STOP that ends a frame with at least one stored data byte raises busy for exactly COMMIT_CYCLES clock cycles. Read data, ref_code, slope_code and gain_shift take the new values only when busy falls.
- R6: A START while busy is high is ignored, and the address that follows is not acknowledged. This covers the first PWRUP_CYCLES cycles after reset as well as every commit.
- R7: gain_shift decodes bits 1:0 of register 2 as follows: 00 gives 0 (x1), 01 gives 1 (x2), 10 gives 1 (x2), 11 gives 2 (x4).
- R8: A START in the middle of a byte aborts the frame. The partial byte is not stored, and address reception starts again.
- R9: While reset is held, sda_oe is 0, busy is 1, and all registers read as 0.
- R10: A STOP after a frame that stored no data byte does not start a commit, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Power-up or commit window in progress |
| ref_code | output | 8 | Committed register 0 |
| slope_code | output | 8 | Committed register 1 |
| gain_shift | output | 2 | Gain as a power of two, decoded from register 2 |

## Verification
A stale or wrong register index appears at the ports within one byte time, as a misplaced acknowledge or a wrong byte on the next read. A frame state that fails to return to idle shows up as an acknowledge given to the wrong address, or to a frame that began during busy. A commit counter that is off by one changes the length of busy, which the bench measures to the cycle. Copying the working bytes too early changes ref_code while busy is still high. A fault in the gain decode shows on gain_shift as soon as the commit ends.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } fsm_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic  en;
        ptr_t  addr;
        byte_t data;
    } wr_req_t;

    function automatic logic [1:0] gain_shift_of(input logic [1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b10:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic ptr_t ptr_next(input ptr_t p, input int nreg);
        return (int'(p) == nreg - 1) ? '0 : ptr_t'(p + 1'b1);
    endfunction

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync
    import cfgi2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_p, sda_p;
    logic              scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_p  <= scl_q;
            sda_p  <= sda_q;
        end
    end

    assign scl_q = scl_sh[STAGES-1];
    assign sda_q = sda_sh[STAGES-1];

    always_comb begin
        ev.scl      = scl_q;
        ev.sda      = sda_q;
        ev.scl_rise = scl_q & ~scl_p;
        ev.scl_fall = ~scl_q & scl_p;
        ev.start    = scl_q & scl_p & sda_p & ~sda_q;
        ev.stop     = scl_q & scl_p & ~sda_p & sda_q;
    end
endmodule

// File: rtl/cfg_i2c_proto.sv
module cfg_i2c_proto
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4A,
    parameter int         NREG     = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic    blocked,
    input  byte_t   rd_data,
    output ptr_t    rd_ptr,
    output wr_req_t wr,
    output logic    commit_req,
    output logic    sda_oe
);
    fsm_t        state;
    logic [3:0]  bitcnt;
    byte_t       sh;
    logic        rw;
    logic        dirty;
    logic        acked;
    ptr_t        ptr;

    assign rd_ptr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            sh         <= '0;
            rw         <= 1'b0;
            dirty      <= 1'b0;
            acked      <= 1'b0;
            ptr        <= '0;
            wr         <= '0;
            commit_req <= 1'b0;
            sda_oe     <= 1'b0;
        end else begin
            wr.en      <= 1'b0;
            commit_req <= 1'b0;
            if (ev.start) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= blocked ? ST_IDLE : ST_ADDR;
            end else if (ev.stop) begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
                if (dirty) commit_req <= 1'b1;
                dirty  <= 1'b0;
            end else if (state == ST_ADDR || state == ST_PTR || state == ST_WDATA) begin
                if (ev.scl_rise && bitcnt < 4'd8) begin
                    sh     <= {sh[BYTE_W-2:0], ev.sda};
                    bitcnt <= bitcnt + 4'd1;
                end else if (ev.scl_fall && bitcnt == 4'd8) begin
                    bitcnt <= '0;
                    if (state == ST_ADDR) begin
                        if (sh[7:1] == DEV_ADDR) begin
                            rw     <= sh[0];
                            sda_oe <= 1'b1;
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end else if (state == ST_PTR) begin
                        if (sh < BYTE_W'(NREG)) begin
                            ptr    <= sh[PTR_W-1:0];
                            sda_oe <= 1'b1;
                            state  <= ST_PTR_ACK;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end else begin
                        wr.en   <= 1'b1;
                        wr.addr <= ptr;
                        wr.data <= sh;
                        ptr     <= ptr_next(ptr, NREG);
                        dirty   <= 1'b1;
                        sda_oe  <= 1'b1;
                        state   <= ST_WDATA_ACK;
                    end
                end
            end else if (state == ST_ADDR_ACK) begin
                if (ev.scl_fall) begin
                    if (rw) begin
                        sh     <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        ptr    <= ptr_next(ptr, NREG);
                        bitcnt <= '0;
                        state  <= ST_RDATA;
                    end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_PTR;
                    end
                end
            end else if (state == ST_PTR_ACK || state == ST_WDATA_ACK) begin
                if (ev.scl_fall) begin
                    sda_oe <= 1'b0;
                    state  <= ST_WDATA;
                end
            end else if (state == ST_RDATA) begin
                if (ev.scl_fall) begin
                    if (bitcnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        acked  <= 1'b0;
                        state  <= ST_RACK;
                    end else begin
                        sh     <= {sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~sh[BYTE_W-2];
                        bitcnt <= bitcnt + 4'd1;
                    end
                end
            end else if (state == ST_RACK) begin
                if (ev.scl_rise) begin
                    acked <= ~ev.sda;
                end else if (ev.scl_fall) begin
                    if (acked) begin
                        sh     <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        ptr    <= ptr_next(ptr, NREG);
                        state  <= ST_RDATA;
                    end else begin
                        state  <= ST_IDLE;
                    end
                end
            end
        end
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(ev.start) && !$past(ev.stop)) |-> !ev.scl); // R1

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < NREG); // R3

endmodule

// File: rtl/cfg_i2c_store.sv
module cfg_i2c_store
    import cfgi2c_pkg::*;
#(
    parameter int NREG          = 5,
    parameter int COMMIT_CYCLES = 1000,
    parameter int PWRUP_CYCLES  = 400
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    input  ptr_t    rd_ptr,
    input  logic    commit_req,
    output byte_t   rd_data,
    output byte_t   ref_o,
    output byte_t   slope_o,
    output logic [1:0] gain_code_o,
    output logic    busy
);
    localparam int CW = $clog2(COMMIT_CYCLES + 1);
    localparam int PW = $clog2(PWRUP_CYCLES + 1);

    byte_t          work [NREG];
    byte_t          keep [NREG];
    logic           commit_act;
    logic [CW-1:0]  commit_cnt;
    logic           pwr_act;
    logic [PW-1:0]  pwr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                work[i] <= '0;
                keep[i] <= '0;
            end
            commit_act <= 1'b0;
            commit_cnt <= '0;
            pwr_act    <= 1'b1;
            pwr_cnt    <= PW'(PWRUP_CYCLES - 1);
        end else begin
            if (wr.en) work[wr.addr] <= wr.data;
            if (pwr_act) begin
                if (pwr_cnt == '0) pwr_act <= 1'b0;
                else               pwr_cnt <= pwr_cnt - 1'b1;
            end
            if (commit_req && !commit_act) begin
                commit_act <= 1'b1;
                commit_cnt <= CW'(COMMIT_CYCLES - 1);
            end else if (commit_act) begin
                if (commit_cnt == '0) begin
                    commit_act <= 1'b0;
                    keep       <= work;
                end else begin
                    commit_cnt <= commit_cnt - 1'b1;
                end
            end
        end
    end

    assign busy        = pwr_act | commit_act;
    assign rd_data     = keep[rd_ptr];
    assign ref_o       = keep[0];
    assign slope_o     = keep[1];
    assign gain_code_o = keep[2][1:0];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_hold
            AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
                !($past(commit_act) && !commit_act) |-> $stable(keep[g])); // R5
        end
    endgenerate

    AST_NO_LOST_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit_req |-> !commit_act); // R5

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR      = 7'h4A,
    parameter int         NREG          = 5,
    parameter int         SYNC_STAGES   = 2,
    parameter int         COMMIT_CYCLES = 1000,
    parameter int         PWRUP_CYCLES  = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic       busy,
    output logic [7:0] ref_code,
    output logic [7:0] slope_code,
    output logic [1:0] gain_shift
);
    bus_ev_t    ev;
    wr_req_t    wr;
    ptr_t       rd_ptr;
    byte_t      rd_data;
    logic       commit_req;
    logic [1:0] gain_code;

    cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    cfg_i2c_proto #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_proto (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .blocked    (busy),
        .rd_data    (rd_data),
        .rd_ptr     (rd_ptr),
        .wr         (wr),
        .commit_req (commit_req),
        .sda_oe     (sda_oe)
    );

    cfg_i2c_store #(
        .NREG          (NREG),
        .COMMIT_CYCLES (COMMIT_CYCLES),
        .PWRUP_CYCLES  (PWRUP_CYCLES)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .rd_ptr      (rd_ptr),
        .commit_req  (commit_req),
        .rd_data     (rd_data),
        .ref_o       (ref_code),
        .slope_o     (slope_code),
        .gain_code_o (gain_code),
        .busy        (busy)
    );

    assign gain_shift = gain_shift_of(gain_code);

    AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !sda_oe); // R6

endmodule

// File: tb/cfg_i2c_target_test.sv
module cfg_i2c_target_test;
    import cfgi2c_pkg::*;

    localparam int         Q      = 5;
    localparam int         COMMIT = 400;
    localparam int         PWRUP  = 400;
    localparam logic [6:0] DEV    = 7'h4A;
    localparam byte_t      AW     = {DEV, 1'b0};
    localparam byte_t      AR     = {DEV, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_tb = 1'b1;
    logic sda_tb = 1'b1;
    logic sda_bus;
    logic sda_oe, busy;
    logic [7:0] ref_code, slope_code;
    logic [1:0] gain_shift;

    assign sda_bus = sda_tb & ~sda_oe;

    always #5 clk = ~clk;

    cfg_i2c_target #(
        .DEV_ADDR      (DEV),
        .COMMIT_CYCLES (COMMIT),
        .PWRUP_CYCLES  (PWRUP)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_tb),
        .sda_in     (sda_bus),
        .sda_oe     (sda_oe),
        .busy       (busy),
        .ref_code   (ref_code),
        .slope_code (slope_code),
        .gain_shift (gain_shift)
    );

    int    checks = 0;
    int    fails = 0;
    int    run = 0;
    int    last_run = 0;
    byte_t exp_q[$];
    byte_t act_q[$];
    string tag_q[$];
    byte_t mon_a, mon_e;
    string mon_t;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: busy run length and read scoreboard
    always @(negedge clk) begin
        if (busy) run++;
        else begin
            if (run > 0) last_run = run;
            run = 0;
        end
        while (act_q.size() > 0) begin
            mon_a = act_q.pop_front();
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected read byte", int'(mon_a), 0);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                chk(mon_a == mon_e, mon_t, "read byte", int'(mon_a), int'(mon_e));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_tb = 1'b1; tick(Q);
        scl_tb = 1'b1; tick(Q);
        sda_tb = 1'b0; tick(Q);
        scl_tb = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_tb = 1'b0; tick(Q);
        scl_tb = 1'b1; tick(Q);
        sda_tb = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input bit b);
        sda_tb = b;    tick(Q);
        scl_tb = 1'b1; tick(2 * Q);
        scl_tb = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output bit b);
        sda_tb = 1'b1; tick(Q);
        scl_tb = 1'b1; tick(Q);
        b = sda_bus;   tick(Q);
        scl_tb = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input byte_t d, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input bit ack_it);
        bit    b;
        byte_t d = '0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            d = {d[6:0], b};
        end
        act_q.push_back(d);
        send_bit(!ack_it);
    endtask

    task automatic expect_rd(input byte_t d, input string tag);
        exp_q.push_back(d);
        tag_q.push_back(tag);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            tick(1);
            n++;
        end
        tick(2);
    endtask

    task automatic write_reg2(input byte_t d);
        bit ak;
        bus_start();
        send_byte(AW, ak);
        send_byte(8'd2, ak);
        send_byte(d, ak);
        chk(ak, "R3", "gain byte ack", ak, 1);
        bus_stop();
        wait_idle();
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        bit ak;
        tick(4);
        // R9 reset state
        chk(sda_oe == 1'b0, "R9", "sda_oe in reset", sda_oe, 0);
        chk(busy == 1'b1, "R9", "busy in reset", busy, 1);
        chk(ref_code == 8'h00 && gain_shift == 2'd0, "R9", "ref_code in reset", ref_code, 0);
        rst = 1'b0;

        // R6 power-up window ignores START
        bus_start();
        send_byte(AW, ak);
        chk(!ak, "R6", "ack during power-up", ak, 0);
        bus_stop();
        wait_idle();
        tick(20);

        // R2 wrong address
        bus_start();
        send_byte(8'h20, ak);
        chk(!ak, "R2", "ack wrong address", ak, 0);
        send_byte(8'h00, ak);
        chk(!ak, "R2", "ack after mismatch", ak, 0);
        bus_stop();
        tick(10);
        chk(!busy, "R2", "busy after mismatch", busy, 0);

        // R2/R3 write three bytes from index 0
        bus_start();
        send_byte(AW, ak);
        chk(ak, "R2", "ack own address", ak, 1);
        send_byte(8'h00, ak);
        chk(ak, "R3", "ack index 0", ak, 1);
        send_byte(8'hA5, ak);
        chk(ak, "R3", "ack data 0", ak, 1);
        send_byte(8'h3C, ak);
        send_byte(8'h81, ak);
        chk(ak, "R3", "ack data 2", ak, 1);
        bus_stop();
        tick(8);
        chk(busy, "R5", "busy after write stop", busy, 1);
        chk(ref_code == 8'h00, "R5", "ref_code before commit end", ref_code, 0);

        // R6 START during commit
        bus_start();
        send_byte(AW, ak);
        chk(!ak, "R6", "ack during commit", ak, 0);
        chk(ref_code == 8'h00, "R5", "ref_code still old", ref_code, 0);
        bus_stop();
        wait_idle();
        chk(last_run == COMMIT, "R5", "commit length", last_run, COMMIT);
        chk(ref_code == 8'hA5, "R5", "ref_code committed", ref_code, 8'hA5);
        chk(slope_code == 8'h3C, "R5", "slope_code committed", slope_code, 8'h3C);
        chk(gain_shift == 2'd1, "R7", "gain code 01", gain_shift, 1);

        // R10 index-only write, then R4 read
        bus_start();
        send_byte(AW, ak);
        send_byte(8'h00, ak);
        bus_stop();
        tick(10);
        chk(!busy, "R10", "busy after index-only frame", busy, 0);
        bus_start();
        send_byte(AR, ak);
        chk(ak, "R4", "ack read address", ak, 1);
        expect_rd(8'hA5, "R4");
        recv_byte(1'b1);
        expect_rd(8'h3C, "R4");
        recv_byte(1'b1);
        expect_rd(8'h81, "R4");
        recv_byte(1'b0);
        bus_stop();
        tick(10);
        chk(sda_oe == 1'b0, "R4", "released after NACK", sda_oe, 0);

        // R3 wrap from 4 to 0
        bus_start();
        send_byte(AW, ak);
        send_byte(8'h04, ak);
        send_byte(8'h77, ak);
        send_byte(8'h11, ak);
        chk(ak, "R3", "ack wrapped byte", ak, 1);
        bus_stop();
        wait_idle();
        chk(ref_code == 8'h11, "R3", "wrap stored to index 0", ref_code, 8'h11);
        bus_start();
        send_byte(AW, ak);
        send_byte(8'h03, ak);
        bus_start();
        send_byte(AR, ak);
        expect_rd(8'h00, "R3");
        recv_byte(1'b1);
        expect_rd(8'h77, "R3");
        recv_byte(1'b1);
        expect_rd(8'h11, "R3");
        recv_byte(1'b0);
        bus_stop();
        tick(10);

        // R3 invalid index
        bus_start();
        send_byte(AW, ak);
        send_byte(8'h05, ak);
        chk(!ak, "R3", "ack index 5", ak, 0);
        send_byte(8'h33, ak);
        chk(!ak, "R3", "ack data after bad index", ak, 0);
        bus_stop();
        tick(10);
        chk(!busy, "R10", "no commit after bad index", busy, 0);

        // R8 START in the middle of a byte
        bus_start();
        send_byte(AW, ak);
        send_byte(8'h02, ak);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b1);
        bus_start();
        send_byte(AW, ak);
        chk(ak, "R8", "ack address after abort", ak, 1);
        send_byte(8'h03, ak);
        send_byte(8'h5A, ak);
        bus_stop();
        wait_idle();
        bus_start();
        send_byte(AW, ak);
        send_byte(8'h02, ak);
        bus_start();
        send_byte(AR, ak);
        expect_rd(8'h81, "R8");
        recv_byte(1'b1);
        expect_rd(8'h5A, "R8");
        recv_byte(1'b0);
        bus_stop();
        tick(10);

        // R7 remaining gain codes
        write_reg2(8'hFC);
        chk(gain_shift == 2'd0, "R7", "gain code 00", gain_shift, 0);
        write_reg2(8'h02);
        chk(gain_shift == 2'd1, "R7", "gain code 10", gain_shift, 1);
        write_reg2(8'h03);
        chk(gain_shift == 2'd2, "R7", "gain code 11", gain_shift, 2);

        tick(20);
        chk(exp_q.size() == 0, "R4", "expected reads left", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule